// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synchronous static memory for an on-chip bus that must be kept busy on every clock. Reads and writes can follow each other in any order with no idle cycle between them. A read returns registered data two enabled clock edges after its command. A write presents its data on the input bus two enabled edges after its address. Because both directions have the same latency, the data bus never has to pause when the traffic switches between reads and writes.

Write data is first placed in a pending-write register. The array is updated only when the next write's data arrives. A read that hits the pending entry takes each enabled lane from that register, so a read always sees the newest value. Each write carries one enable per byte lane. A write with no lane enabled changes nothing.

The block has three chip selects, which allow depth expansion. A clock enable stalls the whole pipeline. A load/continue input repeats the previous operation at a new address; an external burst counter supplies that address. Read data is gated onto the output by an output enable.

Top module: `nobubble_sram`

## Requirements
- R1: A read command taken at enabled edge n drives `rd_valid` high after enabled edge n+2, with `dout` showing the stored word, provided `oe_n` is low.
- R2: The write data for a write command taken at enabled edge n is sampled from `din` at enabled edge n+2.
- R3: While `clk_en_n` is high, no clock edge changes any state or output, and commands already in flight resume afterwards with no loss.
- R4: Reads and writes can be issued on consecutive cycles in either order. A read issued after a write to the same address returns the written data, even while that data is still pending.
- R5: On a write, lane i (bits [9i+8:9i]) is updated only when `bw_n[i]` is low. For each lane, a read returns the newest data for that lane.
- R6: A write with every `bw_n` bit high leaves the addressed word unchanged.
- R7: A loaded command is a deselect unless `cs0_n` is low, `cs1` is high and `cs2_n` is low. A deselect produces no read data and writes nothing.
- R8: Deselect cycles do not stop commands already in the pipeline from completing.
- R9: `rd_valid` is high only for a completed read while `oe_n` is low. Whenever `rd_valid` is low, `dout` is zero. `oe_n` acts without waiting for a clock.
- R10: With `ld_n` high, the previous operation (read, write or deselect) is repeated at the new address, and the chip selects and `rnw` are ignored. After reset, the previous operation is deselect.
- R11: Reset empties the pipeline and holds `rd_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline |
| clk_en_n | input | 1 | Active-low clock enable; high stalls the block |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| ld_n | input | 1 | Low: load a new command; high: repeat the previous operation |
| rnw | input | 1 | 1 = read, 0 = write |
| bw_n | input | LANES | Active-low write enable per byte lane |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data, two enabled edges after its command |
| oe_n | input | 1 | Active-low output enable |
| dout | output | DATA_W | Read data, zero when not valid |
| rd_valid | output | 1 | Read data valid on `dout` |

## Verification
On every cycle, the assertions check the following: a stalled edge freezes the output and pending-write state; a read reaching the second stage produces valid data one edge later, and nothing else does; write data is captured two stages after its address; a deselect loads an empty slot; and the output-enable gating holds. Only the bench scenarios can show that the data values are right. This covers the forwarding of individual lanes from the pending register while other lanes come from the array, aborted writes, repeated operations driven through `ld_n`, and commands draining through deselect cycles and stalls.

// File: rtl/nobubble_sram.sv
`timescale 1ns/1ps
module nobubble_sram #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  localparam int DATA_W = LANE_W * LANES,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic              cs0_n,
  input  logic              cs1,
  input  logic              cs2_n,
  input  logic              ld_n,
  input  logic              rnw,
  input  logic [LANES-1:0]  bw_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              oe_n,
  output logic [DATA_W-1:0] dout,
  output logic              rd_valid
);

  typedef enum logic [1:0] {OP_NONE = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2} op_e;

  logic [LANES-1:0][LANE_W-1:0] mem [DEPTH];

  op_e               last_op, new_op, s1_op, s2_op;
  logic [ADDR_W-1:0] s1_addr, s2_addr, pend_addr;
  logic [LANES-1:0]  s1_be, s2_be, pend_be;
  logic              pend_vld, q_vld;
  logic [DATA_W-1:0] pend_data, q_data, fwd_word;
  logic              sel, adv;

  assign sel    = !cs0_n && cs1 && !cs2_n;
  assign adv    = !clk_en_n;
  assign new_op = ld_n ? last_op : (!sel ? OP_NONE : (rnw ? OP_RD : OP_WR));

  for (genvar l = 0; l < LANES; l++) begin : g_fwd
    assign fwd_word[l*LANE_W +: LANE_W] =
      (pend_vld && pend_be[l] && pend_addr == s2_addr) ? pend_data[l*LANE_W +: LANE_W]
                                                       : mem[s2_addr][l];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_op   <= OP_NONE;
      s1_op     <= OP_NONE;
      s2_op     <= OP_NONE;
      s1_addr   <= '0;
      s2_addr   <= '0;
      s1_be     <= '0;
      s2_be     <= '0;
      pend_vld  <= 1'b0;
      pend_addr <= '0;
      pend_be   <= '0;
      pend_data <= '0;
      q_vld     <= 1'b0;
      q_data    <= '0;
    end else if (adv) begin
      last_op <= new_op;
      s1_op   <= new_op;
      s1_addr <= addr;
      s1_be   <= ~bw_n;
      s2_op   <= s1_op;
      s2_addr <= s1_addr;
      s2_be   <= s1_be;
      q_vld   <= (s2_op == OP_RD);
      if (s2_op == OP_RD) q_data <= fwd_word;
      if (s2_op == OP_WR) begin
        pend_vld  <= 1'b1;
        pend_addr <= s2_addr;
        pend_be   <= s2_be;
        pend_data <= din;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (adv && rst_n && s2_op == OP_WR && pend_vld) begin
      for (int l = 0; l < LANES; l++) begin
        if (pend_be[l]) mem[pend_addr][l] <= pend_data[l*LANE_W +: LANE_W];
      end
    end
  end

  assign rd_valid = q_vld && !oe_n;
  assign dout     = rd_valid ? q_data : '0;

  p_stall_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> $stable(q_vld) && $stable(q_data) && $stable(pend_vld) && $stable(pend_data));

  p_read_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && s2_op == OP_RD) |=> q_vld);

  p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && s2_op != OP_RD) |=> !q_vld);

  p_late_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && s2_op == OP_WR) |=> pend_vld && pend_data == $past(din) && pend_addr == $past(s2_addr));

  p_deselect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !ld_n && !sel) |=> s1_op == OP_NONE);

  p_oe_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !rd_valid && dout == '0);

endmodule

// File: tb/nobubble_sram_bench.sv
`timescale 1ns/1ps
module nobubble_sram_bench;
  localparam int AW = 8, LW = 9, NL = 2, DW = LW * NL;

  logic clk = 1'b0, rst_n = 1'b0, clk_en_n = 1'b0;
  logic cs0_n = 1'b1, cs1 = 1'b0, cs2_n = 1'b1, ld_n = 1'b0, rnw = 1'b1, oe_n = 1'b0;
  logic [NL-1:0] bw_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic rd_valid;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  nobubble_sram #(.ADDR_W(AW), .LANE_W(LW), .LANES(NL)) u_nobubble_sram (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
    .ld_n(ld_n), .rnw(rnw), .bw_n(bw_n), .addr(addr), .din(din), .oe_n(oe_n),
    .dout(dout), .rd_valid(rd_valid));

  typedef struct packed {
    logic          ld_n;
    logic          en;
    logic          rnw;
    logic [1:0]    bw_n;
    logic [7:0]    addr;
    logic [17:0]   din;
    logic          ev;
    logic [17:0]   ed;
    logic [7:0]    tag;
  } vec_t;

  // Inputs apply to edge i; ev/ed is the output expected after edge i.
  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,1'b0,2'b00,8'd10,18'h00000,1'b0,18'h00000,8'd2},  // W 10
    '{1'b0,1'b1,1'b0,2'b00,8'd11,18'h00000,1'b0,18'h00000,8'd4},  // W 11
    '{1'b0,1'b1,1'b1,2'b00,8'd10,18'h12345,1'b0,18'h00000,8'd2},  // R 10, data W10 (R2)
    '{1'b0,1'b1,1'b1,2'b00,8'd11,18'h0ABCD,1'b0,18'h00000,8'd4},  // R 11, data W11 (R4)
    '{1'b0,1'b1,1'b0,2'b10,8'd10,18'h00000,1'b1,18'h12345,8'd1},  // W 10 lane0; out R10 (R1)
    '{1'b0,1'b1,1'b1,2'b11,8'd10,18'h00000,1'b1,18'h0ABCD,8'd4},  // R 10; out R11 pending (R4)
    '{1'b0,1'b0,1'b1,2'b00,8'd0 ,18'h155AA,1'b0,18'h00000,8'd5},  // deselect; lane data
    '{1'b0,1'b1,1'b1,2'b00,8'd10,18'h00000,1'b1,18'h123AA,8'd5},  // R 10; out mixed lanes (R5)
    '{1'b0,1'b1,1'b0,2'b11,8'd11,18'h00000,1'b0,18'h00000,8'd7},  // W 11 abort; desel no out (R7)
    '{1'b0,1'b1,1'b1,2'b00,8'd11,18'h00000,1'b1,18'h123AA,8'd5},  // R 11; out R10 (R5)
    '{1'b0,1'b0,1'b0,2'b00,8'd0 ,18'h3FFFF,1'b0,18'h00000,8'd6},  // data for abort (R6)
    '{1'b0,1'b0,1'b0,2'b00,8'd0 ,18'h00000,1'b1,18'h0ABCD,8'd8},  // drain through desel (R6/R8)
    '{1'b0,1'b1,1'b0,2'b00,8'd30,18'h00000,1'b0,18'h00000,8'd10}, // W 30
    '{1'b1,1'b0,1'b1,2'b00,8'd31,18'h00000,1'b0,18'h00000,8'd10}, // continue write 31 (R10)
    '{1'b0,1'b1,1'b1,2'b00,8'd30,18'h00111,1'b0,18'h00000,8'd10}, // R 30
    '{1'b1,1'b0,1'b0,2'b00,8'd31,18'h22222,1'b0,18'h00000,8'd10}, // continue read 31
    '{1'b0,1'b0,1'b0,2'b00,8'd0 ,18'h00000,1'b1,18'h00111,8'd10},
    '{1'b0,1'b0,1'b0,2'b00,8'd0 ,18'h00000,1'b1,18'h22222,8'd10},
    '{1'b0,1'b0,1'b0,2'b00,8'd0 ,18'h00000,1'b0,18'h00000,8'd10},
    '{1'b1,1'b1,1'b1,2'b00,8'd10,18'h00000,1'b0,18'h00000,8'd10}, // continue after desel
    '{1'b0,1'b0,1'b0,2'b00,8'd0 ,18'h00000,1'b0,18'h00000,8'd10},
    '{1'b0,1'b0,1'b0,2'b00,8'd0 ,18'h00000,1'b0,18'h00000,8'd10}
  };

  task automatic chk(input string req, input logic [DW:0] got, input logic [DW:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cmd(input logic l, input logic en, input logic r, input logic [AW-1:0] a);
    ld_n = l; cs0_n = !en; cs1 = en; cs2_n = !en; rnw = r; addr = a; bw_n = '0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset valid", {1'b0, DW'(rd_valid)}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      ld_n = VEC[i].ld_n; cs0_n = !VEC[i].en; cs1 = VEC[i].en; cs2_n = !VEC[i].en;
      rnw = VEC[i].rnw; bw_n = VEC[i].bw_n; addr = VEC[i].addr; din = VEC[i].din;
      cyc();
      chk($sformatf("R%0d vec %0d", VEC[i].tag, i), {rd_valid, dout}, {VEC[i].ev, VEC[i].ed});
    end

    // R3: stalled read does not advance; resumes afterwards
    cmd(1'b0, 1'b1, 1'b1, 8'd11);
    cyc();
    cmd(1'b0, 1'b0, 1'b0, 8'd0);
    clk_en_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      cyc();
      chk("R3 stall no output", {1'b0, DW'(rd_valid)}, '0);
    end
    clk_en_n = 1'b0;
    cyc();
    chk("R3 resume stage", {1'b0, DW'(rd_valid)}, '0);
    cyc();
    chk("R3 resumed read R1", {rd_valid, dout}, {1'b1, 18'h0ABCD});
    clk_en_n = 1'b1;
    cyc(); cyc();
    chk("R3 output held", {rd_valid, dout}, {1'b1, 18'h0ABCD});

    // R9: output enable gates without a clock
    #1 oe_n = 1'b1;
    #0.5 chk("R9 oe high", {rd_valid, dout}, '0);
    oe_n = 1'b0;
    #0.5 chk("R9 oe low", {rd_valid, dout}, {1'b1, 18'h0ABCD});
    clk_en_n = 1'b0;
    @(negedge clk);
    cyc();
    chk("R9 no read no valid", {rd_valid, dout}, '0);

    // R11: reset mid-flight discards the read
    cmd(1'b0, 1'b1, 1'b1, 8'd10);
    cyc();
    cmd(1'b0, 1'b0, 1'b0, 8'd0);
    #1 rst_n = 1'b0;
    #1 rst_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      cyc();
      chk("R11 flushed", {1'b0, DW'(rd_valid)}, '0);
    end
    // R10: continue right after reset is a deselect
    cmd(1'b1, 1'b1, 1'b1, 8'd10);
    cyc();
    cmd(1'b0, 1'b0, 1'b0, 8'd0);
    cyc(); cyc();
    chk("R10 continue after reset", {1'b0, DW'(rd_valid)}, '0);

    finish_run();
  end
endmodule